// File: doc/BRIEF.md
# SMBus Block-Read Process-Call Master

This block is the bus-master sequencer for one block-read process call on a two-wire SMBus segment. A single-cycle request supplies a 7-bit target address, a starting register address and a requested data length N. The block then drives the complete frame on the open-drain SCL and SDA lines. The frame has a write phase that carries the process-call command, a repeated START, and a read phase. In the read phase the target first returns a length byte and then the data bytes.

Each received data byte appears on a byte stream with a one-cycle valid strobe. When the STOP condition is complete, the block pulses a completion flag and reports three results: whether an expected acknowledge was missing, the length byte the target sent, and whether that byte disagreed with the request. The SCL rate is set by a parameter that divides the system clock into quarter-bit steps. Only this master may drive the bus. The block does not support arbitration with other masters, clock stretching by the target, or packet error checking.

Top module: `smb_blkrd_master`

## Requirements
- R1: After an accepted request the bus carries, in this order: START, {address,0}, F1h, 02h, start register address, N, repeated START, {address,1}. Each byte is 8 bits with the MSB first, and the master releases SDA in the ninth bit slot so the target can acknowledge.
- R2: A request with N = 0 or N > 32 gives a one-cycle `reject_o` pulse in the cycle after the request. The bus is not touched and `busy_o` stays low.
- R3: The master acknowledges the first byte read, which is the length byte, by driving SDA low in its ninth slot. That byte is presented on `cnt_byte_o` by the time `done_o` is pulsed.
- R4: Exactly N data bytes are read. Each one appears on `rx_data_o` with a one-cycle `rx_valid_o` pulse. The master drives ACK after every data byte except the last one, and after the last one it leaves SDA high (NACK).
- R5: A STOP condition follows the final NACK. Then `done_o` pulses for one cycle, in the same cycle that `busy_o` falls.
- R6: If SDA is high in the acknowledge slot of any byte the master sends (including {address,1}), the master goes directly to STOP. It reads no data, and `nack_err_o` is high from that point until the next accepted request.
- R7: If the length byte differs from N, `cnt_mismatch_o` is set at completion, and exactly N data bytes are still read.
- R8: SDA changes while SCL is high only for START and STOP. Data bits change in the middle of the SCL low phase. Within a byte, consecutive SCL rising edges are exactly 4*QDIV clocks apart.
- R9: `busy_o` goes high in the cycle after an accepted request and stays high until the STOP is complete. A request that arrives while `busy_o` is high is ignored, along with the address, register and length that come with it.
- R10: While `busy_o` is low, the block releases both SCL and SDA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request strobe, one cycle |
| tgt_addr_i | input | 7 | Target 7-bit address |
| reg_addr_i | input | 8 | Start register address sent in the write phase |
| req_len_i | input | LEN_W (6) | Requested data byte count N |
| sda_i | input | 1 | Sampled SDA line level |
| scl_low_o | output | 1 | 1 = pull SCL low, 0 = release |
| sda_low_o | output | 1 | 1 = pull SDA low, 0 = release |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle pulse when STOP is complete |
| reject_o | output | 1 | One-cycle pulse for an out-of-range N |
| nack_err_o | output | 1 | Missing acknowledge seen on a sent byte |
| cnt_byte_o | output | 8 | Length byte returned by the target |
| cnt_mismatch_o | output | 1 | Length byte differed from N |
| rx_data_o | output | 8 | Received data byte |
| rx_valid_o | output | 1 | Strobe for rx_data_o |

## Verification
The bench attaches a behavioural target that decodes the wires. It goes after the edges of the length range. At N = 1 the length byte must get an ACK while the only data byte gets a NACK, so a master that tied the NACK to the wrong byte would either leave the target driving the bus or cut off the data. At N = 32 an off-by-one counter would show up as 31 or 33 strobes, and at 0 and 33 a faulty range check would start a transaction. Other cases are a target that refuses the address, a mid-frame byte, or the read address, where a master that kept going would produce data strobes or a second START. The remaining cases are a length byte that disagrees with N (the mismatch flag and the byte count must stay separate) and a second request while busy, which a careless design would latch with its new address.

// File: rtl/smbbr_pkg.sv
package smbbr_pkg;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_STOP  = 2'd1,
    OP_WR    = 2'd2,
    OP_RD    = 2'd3
  } bus_op_t;

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_WADR, S_WCMD, S_WCNT, S_WREG, S_WLEN,
    S_RSTA, S_RADR, S_RCNT, S_RDAT, S_STOP
  } seq_st_t;

endpackage

// File: rtl/smbbr_qtick.sv
module smbbr_qtick #(
  parameter int QDIV = 64
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int CW = (QDIV > 1) ? $clog2(QDIV) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      tick_o <= 1'b0;
    end else if (cnt == CW'(QDIV - 1)) begin
      cnt    <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt    <= cnt + 1'b1;
      tick_o <= 1'b0;
    end
  end
endmodule

// File: rtl/smbbr_byte_phy.sv
module smbbr_byte_phy
  import smbbr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       qtick,
  input  logic       cmd_v,
  input  bus_op_t    cmd_op,
  input  logic [7:0] cmd_byte,
  input  logic       cmd_nack,
  input  logic       sda_i,
  output logic       scl_low_o,
  output logic       sda_low_o,
  output logic       done_o,
  output logic [7:0] rx_byte_o,
  output logic       ack_o,
  output logic       cond_o
);
  logic       active;
  bus_op_t    op;
  logic [1:0] q;
  logic [3:0] bitn;
  logic [7:0] sh;
  logic       nack_r;
  logic       lvl_a, lvl_b, last_bit, is_cond;

  assign is_cond = (op == OP_START) || (op == OP_STOP);
  assign last_bit = is_cond ? (bitn == 4'd0) : (bitn == 4'd8);
  assign cond_o = active && is_cond;

  // Line level for the SCL-low half (a) and for the late SCL-high quarter (b)
  always_comb begin
    unique case (op)
      OP_START: begin lvl_a = 1'b1; lvl_b = 1'b0; end
      OP_STOP:  begin lvl_a = 1'b0; lvl_b = 1'b1; end
      OP_WR:    begin lvl_a = (bitn == 4'd8) ? 1'b1 : sh[7]; lvl_b = lvl_a; end
      default:  begin lvl_a = (bitn == 4'd8) ? nack_r : 1'b1; lvl_b = lvl_a; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      op        <= OP_START;
      q         <= 2'd0;
      bitn      <= 4'd0;
      sh        <= 8'h00;
      nack_r    <= 1'b0;
      scl_low_o <= 1'b0;
      sda_low_o <= 1'b0;
      done_o    <= 1'b0;
      rx_byte_o <= 8'h00;
      ack_o     <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (cmd_v && !active) begin
        active    <= 1'b1;
        op        <= cmd_op;
        q         <= 2'd0;
        bitn      <= 4'd0;
        sh        <= cmd_byte;
        nack_r    <= cmd_nack;
        scl_low_o <= 1'b1;
      end else if (active && qtick) begin
        unique case (q)
          2'd0: begin
            q         <= 2'd1;
            sda_low_o <= ~lvl_a;
          end
          2'd1: begin
            q         <= 2'd2;
            scl_low_o <= 1'b0;
          end
          2'd2: begin
            q         <= 2'd3;
            sda_low_o <= ~lvl_b;
            if (op == OP_RD && bitn != 4'd8) sh <= {sh[6:0], sda_i};
            if (bitn == 4'd8) ack_o <= ~sda_i;
          end
          default: begin
            if (last_bit) begin
              active    <= 1'b0;
              done_o    <= 1'b1;
              rx_byte_o <= sh;
              scl_low_o <= (op != OP_STOP);
            end else begin
              bitn      <= bitn + 4'd1;
              q         <= 2'd0;
              scl_low_o <= 1'b1;
              if (op == OP_WR) sh <= {sh[6:0], 1'b0};
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/smbbr_seq.sv
module smbbr_seq
  import smbbr_pkg::*;
#(
  parameter int         MAX_LEN  = 32,
  parameter int         LEN_W    = 6,
  parameter logic [7:0] CMD_CODE = 8'hF1,
  parameter logic [7:0] WR_COUNT = 8'h02
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [6:0]       tgt_addr_i,
  input  logic [7:0]       reg_addr_i,
  input  logic [LEN_W-1:0] req_len_i,
  input  logic             eng_done,
  input  logic [7:0]       eng_rx,
  input  logic             eng_ack,
  output logic             cmd_v,
  output bus_op_t          cmd_op,
  output logic [7:0]       cmd_byte,
  output logic             cmd_nack,
  output logic             busy_o,
  output logic             done_o,
  output logic             reject_o,
  output logic             nack_err_o,
  output logic [7:0]       cnt_byte_o,
  output logic             cnt_mismatch_o,
  output logic [7:0]       rx_data_o,
  output logic             rx_valid_o
);
  seq_st_t          st;
  logic             issued;
  logic [6:0]       addr_r;
  logic [7:0]       reg_r;
  logic [LEN_W-1:0] len_r, rem;
  logic             len_ok;

  assign len_ok = (req_len_i != '0) && (req_len_i <= LEN_W'(MAX_LEN));

  always_comb begin
    cmd_op   = OP_WR;
    cmd_byte = 8'h00;
    cmd_nack = 1'b0;
    unique case (st)
      S_START, S_RSTA: cmd_op = OP_START;
      S_STOP:          cmd_op = OP_STOP;
      S_WADR:          cmd_byte = {addr_r, 1'b0};
      S_WCMD:          cmd_byte = CMD_CODE;
      S_WCNT:          cmd_byte = WR_COUNT;
      S_WREG:          cmd_byte = reg_r;
      S_WLEN:          cmd_byte = 8'(len_r);
      S_RADR:          cmd_byte = {addr_r, 1'b1};
      S_RCNT:          cmd_op = OP_RD;
      S_RDAT: begin
        cmd_op   = OP_RD;
        cmd_nack = (rem == LEN_W'(1));
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st             <= S_IDLE;
      issued         <= 1'b0;
      addr_r         <= 7'h00;
      reg_r          <= 8'h00;
      len_r          <= '0;
      rem            <= '0;
      cmd_v          <= 1'b0;
      busy_o         <= 1'b0;
      done_o         <= 1'b0;
      reject_o       <= 1'b0;
      nack_err_o     <= 1'b0;
      cnt_byte_o     <= 8'h00;
      cnt_mismatch_o <= 1'b0;
      rx_data_o      <= 8'h00;
      rx_valid_o     <= 1'b0;
    end else begin
      cmd_v      <= 1'b0;
      done_o     <= 1'b0;
      reject_o   <= 1'b0;
      rx_valid_o <= 1'b0;
      if (st == S_IDLE) begin
        if (start_i) begin
          if (len_ok) begin
            st             <= S_START;
            issued         <= 1'b0;
            busy_o         <= 1'b1;
            addr_r         <= tgt_addr_i;
            reg_r          <= reg_addr_i;
            len_r          <= req_len_i;
            nack_err_o     <= 1'b0;
            cnt_mismatch_o <= 1'b0;
          end else begin
            reject_o <= 1'b1;
          end
        end
      end else if (!issued) begin
        cmd_v  <= 1'b1;
        issued <= 1'b1;
      end else if (eng_done) begin
        issued <= 1'b0;
        unique case (st)
          S_START: st <= S_WADR;
          S_WADR, S_WCMD, S_WCNT, S_WREG, S_WLEN, S_RADR: begin
            if (!eng_ack) begin
              nack_err_o <= 1'b1;
              st         <= S_STOP;
            end else begin
              unique case (st)
                S_WADR:  st <= S_WCMD;
                S_WCMD:  st <= S_WCNT;
                S_WCNT:  st <= S_WREG;
                S_WREG:  st <= S_WLEN;
                S_WLEN:  st <= S_RSTA;
                default: st <= S_RCNT;
              endcase
            end
          end
          S_RSTA: st <= S_RADR;
          S_RCNT: begin
            cnt_byte_o     <= eng_rx;
            cnt_mismatch_o <= (eng_rx != 8'(len_r));
            rem            <= len_r;
            st             <= S_RDAT;
          end
          S_RDAT: begin
            rx_data_o  <= eng_rx;
            rx_valid_o <= 1'b1;
            rem        <= rem - LEN_W'(1);
            if (rem == LEN_W'(1)) st <= S_STOP;
          end
          S_STOP: begin
            busy_o <= 1'b0;
            done_o <= 1'b1;
            st     <= S_IDLE;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/smb_blkrd_master.sv
module smb_blkrd_master
  import smbbr_pkg::*;
#(
  parameter int QDIV    = 64,
  parameter int MAX_LEN = 32,
  parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [6:0]       tgt_addr_i,
  input  logic [7:0]       reg_addr_i,
  input  logic [LEN_W-1:0] req_len_i,
  input  logic             sda_i,
  output logic             scl_low_o,
  output logic             sda_low_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             reject_o,
  output logic             nack_err_o,
  output logic [7:0]       cnt_byte_o,
  output logic             cnt_mismatch_o,
  output logic [7:0]       rx_data_o,
  output logic             rx_valid_o
);
  logic       qtick;
  logic       cmd_v, cmd_nack;
  bus_op_t    cmd_op;
  logic [7:0] cmd_byte;
  logic       eng_done, eng_ack, eng_cond;
  logic [7:0] eng_rx;

  smbbr_qtick #(.QDIV(QDIV)) u_tick (
    .clk(clk), .rst(rst), .tick_o(qtick)
  );

  smbbr_byte_phy u_phy (
    .clk(clk), .rst(rst), .qtick(qtick),
    .cmd_v(cmd_v), .cmd_op(cmd_op), .cmd_byte(cmd_byte), .cmd_nack(cmd_nack),
    .sda_i(sda_i), .scl_low_o(scl_low_o), .sda_low_o(sda_low_o),
    .done_o(eng_done), .rx_byte_o(eng_rx), .ack_o(eng_ack), .cond_o(eng_cond)
  );

  smbbr_seq #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst(rst), .start_i(start_i),
    .tgt_addr_i(tgt_addr_i), .reg_addr_i(reg_addr_i), .req_len_i(req_len_i),
    .eng_done(eng_done), .eng_rx(eng_rx), .eng_ack(eng_ack),
    .cmd_v(cmd_v), .cmd_op(cmd_op), .cmd_byte(cmd_byte), .cmd_nack(cmd_nack),
    .busy_o(busy_o), .done_o(done_o), .reject_o(reject_o),
    .nack_err_o(nack_err_o), .cnt_byte_o(cnt_byte_o),
    .cnt_mismatch_o(cnt_mismatch_o), .rx_data_o(rx_data_o), .rx_valid_o(rx_valid_o)
  );
endmodule

// File: rtl/smbbr_chk.sv
module smbbr_chk (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic done,
  input logic reject,
  input logic nack_err,
  input logic rx_valid,
  input logic scl_low,
  input logic sda_low,
  input logic cond
);
  AST_IDLE_BUS_FREE: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!scl_low && !sda_low)); // R10

  AST_REJECT_NO_BUSY: assert property (@(posedge clk) disable iff (rst)
    reject |-> !busy); // R2

  AST_RX_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> busy); // R4

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> $fell(busy)); // R5

  AST_SDA_HIGH_SCL: assert property (@(posedge clk) disable iff (rst)
    (!$stable(sda_low) && !scl_low && !$past(scl_low)) |-> cond); // R8

  AST_ERR_NO_DATA: assert property (@(posedge clk) disable iff (rst)
    nack_err |-> !rx_valid); // R6
endmodule

bind smb_blkrd_master smbbr_chk u_chk (
  .clk(clk), .rst(rst), .busy(busy_o), .done(done_o), .reject(reject_o),
  .nack_err(nack_err_o), .rx_valid(rx_valid_o), .scl_low(scl_low_o),
  .sda_low(sda_low_o), .cond(eng_cond)
);

// File: tb/sim_smb_blkrd_master.sv
`timescale 1ns/1ps
module sim_smb_blkrd_master;
  localparam int QDIV = 4;
  localparam logic [6:0] SLV = 7'h2C;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic [6:0] tgt_addr_i = 7'h00;
  logic [7:0] reg_addr_i = 8'h00;
  logic [5:0] req_len_i = 6'd0;
  logic scl_low_o, sda_low_o, busy_o, done_o, reject_o, nack_err_o;
  logic cnt_mismatch_o, rx_valid_o;
  logic [7:0] cnt_byte_o, rx_data_o;
  logic slv_low = 1'b0;
  logic sda_line, scl_line;

  assign sda_line = !(sda_low_o || slv_low);
  assign scl_line = !scl_low_o;

  always #2.5 clk = ~clk;

  smb_blkrd_master #(.QDIV(QDIV)) u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .tgt_addr_i(tgt_addr_i),
    .reg_addr_i(reg_addr_i), .req_len_i(req_len_i), .sda_i(sda_line),
    .scl_low_o(scl_low_o), .sda_low_o(sda_low_o), .busy_o(busy_o),
    .done_o(done_o), .reject_o(reject_o), .nack_err_o(nack_err_o),
    .cnt_byte_o(cnt_byte_o), .cnt_mismatch_o(cnt_mismatch_o),
    .rx_data_o(rx_data_o), .rx_valid_o(rx_valid_o)
  );

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // target model state and settings
  int cfg_reply = 0, cfg_nack_at = -1;
  logic [7:0] cur_reg = 8'h00;
  byte unsigned wr_q[$];
  bit mack_q[$];
  byte unsigned rx_q[$];
  int n_start = 0, n_stop = 0;
  bit done_seen = 0;
  int bitn = -1, byte_no = 0, txk = 0;
  bit in_fr = 0, tx = 0, go_tx = 0, stop_tx = 0, addr_next = 0, give_ack = 0;
  logic [7:0] sh = 8'h00, txb = 8'h00;
  logic scl_p = 1'b1, sda_p = 1'b1;
  int cyc = 0, last_rise = -1, short_iv = 0;
  bit exact_iv = 0;
  logic st_q = 1'b0;
  logic [5:0] len_q = 6'd0;
  bit exp_busy = 0;

  function automatic logic [7:0] dat(input int k);
    return 8'h30 + cur_reg + 8'(k);
  endfunction

  always @(posedge clk) begin
    st_q  <= start_i;
    len_q <= req_len_i;
  end

  // per-clock reference and target model, sampled away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (rst) begin
      exp_busy = 0;
    end else begin
      if (st_q && !exp_busy && len_q >= 1 && len_q <= 32) exp_busy = 1;
      if (done_o) begin exp_busy = 0; done_seen = 1; end
      chk(busy_o == exp_busy, "R9", "busy per clock", busy_o, exp_busy);
      if (!busy_o) chk(scl_line && sda_line, "R10", "idle lines released", {scl_line, sda_line}, 3);
      if (rx_valid_o) rx_q.push_back(rx_data_o);
    end
    if (scl_p && scl_line && sda_p && !sda_line) begin
      n_start++; in_fr = 1; bitn = -1; tx = 0; slv_low = 1'b0; addr_next = 1;
    end else if (scl_p && scl_line && !sda_p && sda_line) begin
      n_stop++; in_fr = 0; tx = 0; slv_low = 1'b0; byte_no = 0; last_rise = -1;
    end else if (in_fr && scl_p && !scl_line) begin
      bitn++;
      if (bitn == 9) bitn = 0;
      if (!tx) begin
        if (bitn == 8) slv_low = give_ack;
        else begin
          slv_low = 1'b0;
          if (bitn == 0 && go_tx) begin
            tx = 1; go_tx = 0; stop_tx = 0; txk = 0;
            txb = 8'(cfg_reply); slv_low = !txb[7];
          end
        end
      end else begin
        if (bitn == 8) slv_low = 1'b0;
        else if (bitn == 0) begin
          if (stop_tx) begin tx = 0; slv_low = 1'b0; end
          else begin txk++; txb = dat(txk); slv_low = !txb[7]; end
        end else slv_low = !txb[7-bitn];
      end
    end else if (in_fr && !scl_p && scl_line) begin
      if (last_rise >= 0) begin
        if (cyc - last_rise < 4*QDIV) short_iv++;
        if (cyc - last_rise == 4*QDIV) exact_iv = 1;
      end
      last_rise = cyc;
      if (!tx && bitn >= 0 && bitn < 8) begin
        sh = {sh[6:0], sda_line};
        if (bitn == 7) begin
          wr_q.push_back(sh);
          if (addr_next) begin
            give_ack = (sh[7:1] == SLV) && (byte_no != cfg_nack_at);
            go_tx = give_ack && sh[0];
            addr_next = 0;
          end else give_ack = (byte_no != cfg_nack_at);
          byte_no++;
        end
      end
      if (tx && bitn == 8) begin
        mack_q.push_back(!sda_line);
        if (sda_line) stop_tx = 1;
      end
    end
    scl_p = scl_line;
    sda_p = sda_line;
    if (cyc > 150000) begin
      chk(0, "WDOG", "watchdog expired", cyc, 150000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  // launch one request; poke > 0 fires a second request that many cycles in
  task automatic run(input logic [6:0] a, input logic [7:0] r, input int n,
                     input int reply, input int nack_at, input int poke,
                     output bit rej);
    int t;
    @(negedge clk);
    wr_q.delete(); mack_q.delete(); rx_q.delete();
    n_start = 0; n_stop = 0; done_seen = 0; short_iv = 0; exact_iv = 0;
    cfg_reply = reply; cfg_nack_at = nack_at; cur_reg = r;
    tgt_addr_i = a; reg_addr_i = r; req_len_i = 6'(n); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    rej = reject_o;
    if (rej) begin
      repeat (200) @(negedge clk);
      return;
    end
    t = 0;
    while (!done_seen && t < 20000) begin
      if (poke > 0 && t == poke) begin
        tgt_addr_i = 7'h11; reg_addr_i = 8'hEE; req_len_i = 6'd5; start_i = 1'b1;
      end else start_i = 1'b0;
      @(negedge clk);
      t++;
    end
    start_i = 1'b0;
    chk(done_seen, "R5", "completion pulse seen", done_seen, 1);
    repeat (60) @(negedge clk);
  endtask

  task automatic check_ok(input logic [6:0] a, input logic [7:0] r, input int n,
                          input int reply);
    bit good;
    byte unsigned exp_w[6];
    exp_w = '{{a, 1'b0}, 8'hF1, 8'h02, r, 8'(n), {a, 1'b1}};
    chk(wr_q.size() == 6, "R1", "bytes sent", wr_q.size(), 6);
    good = 1;
    foreach (exp_w[i]) if (i >= wr_q.size() || wr_q[i] != exp_w[i]) good = 0;
    chk(good, "R1", "frame byte order", wr_q.size() > 3 ? int'(wr_q[3]) : -1, int'(r));
    chk(n_start == 2 && n_stop == 1, "R1", "START/STOP count", n_start*10 + n_stop, 21);
    chk(cnt_byte_o == 8'(reply), "R3", "length byte", cnt_byte_o, reply);
    chk(cnt_mismatch_o == (reply != n), "R7", "mismatch flag", cnt_mismatch_o, reply != n);
    chk(nack_err_o == 0, "R6", "no error flag", nack_err_o, 0);
    chk(rx_q.size() == n, "R4", "data byte count", rx_q.size(), n);
    good = 1;
    foreach (rx_q[i]) if (rx_q[i] != dat(i + 1)) good = 0;
    chk(good, "R4", "data values", rx_q.size() > 0 ? int'(rx_q[0]) : -1, int'(dat(1)));
    chk(mack_q.size() == n + 1, "R4", "acknowledge slots read", mack_q.size(), n + 1);
    good = (mack_q.size() == n + 1);
    foreach (mack_q[i]) if (mack_q[i] != (i < n)) good = 0;
    chk(good, "R3", "ACK length byte, ACK data, NACK last",
        mack_q.size() > 0 ? int'(mack_q[mack_q.size()-1]) : -1, 0);
    chk(short_iv == 0, "R8", "no short SCL period", short_iv, 0);
    chk(exact_iv, "R8", "SCL period of 4*QDIV seen", exact_iv, 1);
    chk(busy_o == 0, "R5", "busy low after stop", busy_o, 0);
  endtask

  task automatic check_err(input int exp_bytes);
    chk(nack_err_o == 1, "R6", "error flag", nack_err_o, 1);
    chk(wr_q.size() == exp_bytes, "R6", "bytes before stop", wr_q.size(), exp_bytes);
    chk(n_stop == 1, "R6", "stop issued", n_stop, 1);
    chk(rx_q.size() == 0, "R6", "no data read", rx_q.size(), 0);
    chk(mack_q.size() == 0, "R6", "no read slots", mack_q.size(), 0);
  endtask

  initial begin
    bit rj;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy_o == 0 && done_o == 0 && reject_o == 0, "R10", "reset outputs",
        {busy_o, done_o, reject_o}, 0);
    chk(scl_line && sda_line, "R10", "reset bus released", {scl_line, sda_line}, 3);

    run(SLV, 8'h10, 1, 1, -1, 0, rj);
    chk(!rj, "R2", "N=1 accepted", rj, 0);
    check_ok(SLV, 8'h10, 1, 1);

    run(SLV, 8'h42, 4, 4, -1, 0, rj);
    check_ok(SLV, 8'h42, 4, 4);

    run(SLV, 8'hC0, 32, 32, -1, 0, rj);
    check_ok(SLV, 8'hC0, 32, 32);

    run(SLV, 8'h20, 0, 0, -1, 0, rj);
    chk(rj, "R2", "N=0 rejected", rj, 1);
    chk(n_start == 0 && busy_o == 0, "R2", "N=0 bus untouched", n_start, 0);

    run(SLV, 8'h20, 33, 0, -1, 0, rj);
    chk(rj, "R2", "N=33 rejected", rj, 1);
    chk(n_start == 0 && busy_o == 0, "R2", "N=33 bus untouched", n_start, 0);

    run(7'h13, 8'h20, 3, 3, -1, 0, rj);
    check_err(1);
    chk(n_start == 1, "R6", "no repeated start after address NACK", n_start, 1);

    run(SLV, 8'h20, 3, 3, 3, 0, rj);
    check_err(4);

    run(SLV, 8'h20, 3, 3, 5, 0, rj);
    check_err(6);
    chk(n_start == 2, "R6", "read address refused", n_start, 2);

    run(SLV, 8'h55, 3, 5, -1, 0, rj);
    check_ok(SLV, 8'h55, 3, 5);
    chk(cnt_mismatch_o == 1, "R7", "mismatch raised", cnt_mismatch_o, 1);

    run(SLV, 8'h08, 2, 2, -1, 300, rj);
    check_ok(SLV, 8'h08, 2, 2);
    chk(n_start == 2, "R9", "request while busy ignored", n_start, 2);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule